// File: doc/BRIEF.md
# Compare and Conditional Move Unit

This unit evaluates one integer compare or one conditional move per cycle on 64-bit operands. A compare relates operand A to operand B, where B can be swapped for an 8-bit literal that is zero-extended. It yields a 64-bit result of exactly 1 or 0. A conditional move tests operand A by itself, either against zero as a signed number or by its least significant bit. When the test succeeds, the unit forwards B, or the literal, as the new destination value.

When the test fails, the unit passes the destination's current value, supplied on `dest_old`, back out unchanged. A separate `write_en` flag tells the register file whether the destination is really updated. Results are registered and appear one clock after `in_valid`, marked by `out_valid`.

A two-state controller tracks the output stage. In state ST_IDLE no result is presented. In state ST_PRESENT the result captured on the previous edge is on the outputs. The transition "accept" (`in_valid` high) leads from either state into ST_PRESENT. The transition "drain" (`in_valid` low) leads from either state into ST_IDLE. Reset forces ST_IDLE.

Top module: `cmov_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `write_en` and `result` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high at the clock edge. Otherwise it is low.
- R3: Operation code 0 (equal) produces `result` = 1 when A equals the second operand and 0 otherwise, with `write_en` = 1.
- R4: Codes 1 (less-or-equal) and 2 (less-than) compare A and the second operand as signed 64-bit values. They return 1 or 0 with `write_en` = 1.
- R5: Codes 3 (less-or-equal) and 4 (less-than) compare as unsigned 64-bit values. They return 1 or 0 with `write_en` = 1.
- R6: When `use_lit` is 1, the 8-bit `lit` is zero-extended and replaces `b` as the second operand, for both compares and moves.
- R7: Move codes 8 (A = 0), 9 (A != 0), 10 (A <= 0), 11 (A < 0), 12 (A >= 0) and 13 (A > 0) treat A as a signed 64-bit value.
- R8: Move code 14 succeeds when bit 0 of A is 1. Code 15 succeeds when bit 0 of A is 0.
- R9: A move whose test succeeds gives `write_en` = 1 and `result` = second operand.
- R10: A move whose test fails gives `write_en` = 0 and `result` = `dest_old`.
- R11: Codes 5, 6 and 7 are reserved. They give `write_en` = 0 and `result` = `dest_old`.
- R12: `write_en` is 0 in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 4 | Operation code (see R3 to R11) |
| use_lit | input | 1 | Select the literal in place of `b` |
| a | input | 64 | First operand / tested operand |
| b | input | 64 | Second operand / move source |
| lit | input | 8 | Literal, zero-extended when selected |
| dest_old | input | 64 | Current destination value |
| out_valid | output | 1 | Registered result is valid |
| write_en | output | 1 | Destination should be written |
| result | output | 64 | Compare flag, moved value or old destination |

## Verification
Two things can fall in the same cycle: capturing a new operation and presenting the previous operation's result. The vector loop drives `in_valid` on every cycle, so each new operation is captured on the same edge where the prior result becomes visible. Each result is judged at the falling edge after its capture, against a value worked out by hand for the vector table. A second overlap is checked in the same way: a failing move is paired with a `b` that differs from `dest_old`, so a wrongly taken move shows up in the pass-through value.

// File: rtl/cmov_pkg.sv
package cmov_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_CEQ  = 4'd0,
        OP_CLE  = 4'd1,
        OP_CLT  = 4'd2,
        OP_CULE = 4'd3,
        OP_CULT = 4'd4,
        OP_MEQ  = 4'd8,
        OP_MNE  = 4'd9,
        OP_MLE  = 4'd10,
        OP_MLT  = 4'd11,
        OP_MGE  = 4'd12,
        OP_MGT  = 4'd13,
        OP_MLBS = 4'd14,
        OP_MLBC = 4'd15
    } op_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } st_e;

endpackage

// File: rtl/cmov_operand_sel.sv
module cmov_operand_sel #(
    parameter int DATA_W = 64,
    parameter int LIT_W  = 8
) (
    input  logic              use_lit,
    input  logic [DATA_W-1:0] b,
    input  logic [LIT_W-1:0]  lit,
    output logic [DATA_W-1:0] b_eff
);
    localparam int PAD_W = DATA_W - LIT_W;

    always_comb begin
        if (use_lit) b_eff = {{PAD_W{1'b0}}, lit};
        else         b_eff = b;
    end
endmodule

// File: rtl/cmov_cmp_eval.sv
module cmov_cmp_eval
    import cmov_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              is_cmp,
    output logic              hit
);
    always_comb begin
        is_cmp = 1'b1;
        hit    = 1'b0;
        case (op)
            OP_CEQ:  hit = (a == b);
            OP_CLE:  hit = ($signed(a) <= $signed(b));
            OP_CLT:  hit = ($signed(a) <  $signed(b));
            OP_CULE: hit = (a <= b);
            OP_CULT: hit = (a <  b);
            default: is_cmp = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmov_cond_eval.sv
module cmov_cond_eval
    import cmov_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    output logic              is_mov,
    output logic              take
);
    logic zero, neg;

    always_comb begin
        zero   = (a == '0);
        neg    = a[DATA_W-1];
        is_mov = 1'b1;
        take   = 1'b0;
        case (op)
            OP_MEQ:  take = zero;
            OP_MNE:  take = !zero;
            OP_MLE:  take = neg || zero;
            OP_MLT:  take = neg;
            OP_MGE:  take = !neg;
            OP_MGT:  take = !neg && !zero;
            OP_MLBS: take = a[0];
            OP_MLBC: take = !a[0];
            default: is_mov = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmov_unit.sv
module cmov_unit
    import cmov_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LIT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic              use_lit,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [LIT_W-1:0]  lit,
    input  logic [DATA_W-1:0] dest_old,
    output logic              out_valid,
    output logic              write_en,
    output logic [DATA_W-1:0] result
);
    localparam int FLAG_PAD = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              is_cmp, hit, is_mov, take;
    logic              we_c;
    logic [DATA_W-1:0] res_c;
    st_e               state, state_nx;
    logic              we_q;
    logic [DATA_W-1:0] res_q;

    cmov_operand_sel #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_sel (
        .use_lit (use_lit),
        .b       (b),
        .lit     (lit),
        .b_eff   (b_eff)
    );

    cmov_cmp_eval #(.DATA_W(DATA_W)) u_cmp (
        .op      (op),
        .a       (a),
        .b       (b_eff),
        .is_cmp  (is_cmp),
        .hit     (hit)
    );

    cmov_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .op      (op),
        .a       (a),
        .is_mov  (is_mov),
        .take    (take)
    );

    always_comb begin
        we_c = is_cmp || (is_mov && take);
        if (is_cmp)    res_c = {{FLAG_PAD{1'b0}}, hit};
        else if (we_c) res_c = b_eff;
        else           res_c = dest_old;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = in_valid ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_nx = in_valid ? ST_PRESENT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q  <= 1'b0;
            res_q <= '0;
        end else if (in_valid) begin
            we_q  <= we_c;
            res_q <= res_c;
        end else begin
            we_q  <= 1'b0;
        end
    end

    assign out_valid = (state == ST_PRESENT);
    assign write_en  = we_q;
    assign result    = res_q;
endmodule

// File: rtl/cmov_unit_chk.sv
module cmov_unit_chk #(
    parameter int DATA_W = 64,
    parameter int LIT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic              use_lit,
    input logic [DATA_W-1:0] b,
    input logic [LIT_W-1:0]  lit,
    input logic [DATA_W-1:0] dest_old,
    input logic              out_valid,
    input logic              write_en,
    input logic [DATA_W-1:0] result
);
    localparam int PAD_W = DATA_W - LIT_W;

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_we_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !write_en);

    p_cmp_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 4'd4) |=> (write_en && result[DATA_W-1:1] == '0));

    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd5 && op <= 4'd7) |=> (!write_en && result == $past(dest_old)));

    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !write_en) |-> result == $past(dest_old));

    p_move_val_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[3] && !use_lit) |=> (!write_en || result == $past(b)));

    p_move_lit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[3] && use_lit) |=> (!write_en || result == {{PAD_W{1'b0}}, $past(lit)}));
endmodule

bind cmov_unit cmov_unit_chk #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .use_lit   (use_lit),
    .b         (b),
    .lit       (lit),
    .dest_old  (dest_old),
    .out_valid (out_valid),
    .write_en  (write_en),
    .result    (result)
);

// File: tb/sim_cmov_unit.sv
`timescale 1ns/1ps
module sim_cmov_unit;
    localparam int DW = 64;
    localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] OLD  = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] SRC  = 64'h0000_1111_2222_3333;

    typedef struct packed {
        logic [3:0]  op;
        logic        sel;
        logic [63:0] a;
        logic [63:0] b;
        logic [7:0]  lit;
        logic [63:0] old;
        logic        we;
        logic [63:0] res;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b0, 64'd5, 64'd5, 8'd0, OLD, 1'b1, 64'd1},               // R3
        '{4'd0,  1'b0, 64'd5, 64'd6, 8'd0, OLD, 1'b1, 64'd0},               // R3
        '{4'd1,  1'b0, NEG1,  64'd1, 8'd0, OLD, 1'b1, 64'd1},               // R4
        '{4'd2,  1'b0, 64'd1, NEG1,  8'd0, OLD, 1'b1, 64'd0},               // R4
        '{4'd2,  1'b0, 64'd3, 64'd3, 8'd0, OLD, 1'b1, 64'd0},               // R4
        '{4'd1,  1'b0, 64'd3, 64'd3, 8'd0, OLD, 1'b1, 64'd1},               // R4
        '{4'd3,  1'b0, NEG1,  64'd1, 8'd0, OLD, 1'b1, 64'd0},               // R5
        '{4'd4,  1'b0, 64'd1, NEG1,  8'd0, OLD, 1'b1, 64'd1},               // R5
        '{4'd4,  1'b0, 64'd7, 64'd7, 8'd0, OLD, 1'b1, 64'd0},               // R5
        '{4'd0,  1'b1, 64'hAB, 64'd0, 8'hAB, OLD, 1'b1, 64'd1},             // R6
        '{4'd2,  1'b1, 64'h10, 64'd0, 8'hFF, OLD, 1'b1, 64'd1},             // R6
        '{4'd8,  1'b0, 64'd0, SRC,   8'd0, OLD, 1'b1, SRC},                 // R7 R9
        '{4'd8,  1'b0, 64'd1, SRC,   8'd0, OLD, 1'b0, OLD},                 // R7 R10
        '{4'd9,  1'b0, 64'h8000_0000_0000_0000, SRC, 8'd0, OLD, 1'b1, SRC}, // R7
        '{4'd10, 1'b0, 64'd0, SRC,   8'd0, OLD, 1'b1, SRC},                 // R7
        '{4'd11, 1'b0, 64'd0, SRC,   8'd0, OLD, 1'b0, OLD},                 // R7 R10
        '{4'd12, 1'b0, 64'h8000_0000_0000_0000, SRC, 8'd0, OLD, 1'b0, OLD}, // R7
        '{4'd13, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, SRC, 8'h5A, OLD, 1'b1, 64'h5A}, // R6 R9
        '{4'd14, 1'b0, 64'd3, SRC,   8'd0, OLD, 1'b1, SRC},                 // R8
        '{4'd15, 1'b0, 64'd3, SRC,   8'd0, OLD, 1'b0, OLD},                 // R8
        '{4'd15, 1'b0, 64'd2, SRC,   8'd0, OLD, 1'b1, SRC},                 // R8
        '{4'd6,  1'b0, 64'd0, SRC,   8'd0, OLD, 1'b0, OLD}                  // R11
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] op = '0;
    logic use_lit = 1'b0;
    logic [63:0] a = '0, b = '0, dest_old = '0;
    logic [7:0] lit = '0;
    logic out_valid, write_en;
    logic [63:0] result;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    cmov_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_lit(use_lit),
        .a(a), .b(b), .lit(lit), .dest_old(dest_old),
        .out_valid(out_valid), .write_en(write_en), .result(result)
    );

    function automatic string req_of(vec_t v);
        string r;
        if (v.op >= 4'd5 && v.op <= 4'd7) r = "R11";
        else if (v.op == 4'd0)            r = "R3";
        else if (v.op <= 4'd2)            r = "R4";
        else if (v.op <= 4'd4)            r = "R5";
        else if (v.op >= 4'd14)           r = "R8";
        else                              r = "R7";
        if (v.sel) r = {r, "/R6"};
        if (v.op[3]) r = {r, v.we ? "/R9" : "/R10"};
        return r;
    endfunction

    task automatic check(string req, logic v, logic w, logic [63:0] r,
                         logic ev, logic ew, logic [63:0] er);
        checks++;
        if (v !== ev || w !== ew || r !== er) begin
            fails++;
            $display("FAIL %s: got valid=%b we=%b res=%h, expected valid=%b we=%b res=%h",
                     req, v, w, r, ev, ew, er);
        end
    endtask

    task automatic drive(vec_t v);
        in_valid = 1'b1; op = v.op; use_lit = v.sel;
        a = v.a; b = v.b; lit = v.lit; dest_old = v.old;
    endtask

    initial begin
        #1000000;
        fails++; checks++;
        $display("FAIL watchdog: got running, expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", out_valid, write_en, result, 1'b0, 1'b0, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", out_valid, write_en, result, 1'b0, 1'b0, 64'd0);
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check(req_of(VECS[i]), out_valid, write_en, result, 1'b1, VECS[i].we, VECS[i].res);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R2/R12 drain", out_valid, write_en, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(VECS[11]);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset wins", out_valid, write_en, result, 1'b0, 1'b0, 64'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 after reset", out_valid, write_en, result, 1'b0, 1'b0, 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule